// File: doc/BRIEF.md
# NAND Page Read Pointer Controller

This block is the device-side control for the read path of a small-page NAND memory. It takes command and address bus cycles and keeps an area pointer. The pointer selects one of three regions of a 528-byte page: the lower main half, the upper main half or the spare tail. Once the last address cycle arrives, the block holds its ready output low while the addressed page loads into the page buffer. After that, each read-enable strobe sends out the next byte, up to the last column of the page.

If the strobes keep coming past the end of the page and chip enable stays low, the next page in the same block loads and output resumes at column 0. At the last page of a block, the block drives zeros and keeps ready high. A mode input turns off automatic continuation. A computed function stands in for the flash cells. Inputs are sampled on the rising clock edge, and the reset is synchronous and active high.

Top module: `nand_rdptr_ctrl`

## Requirements
- R1: A command cycle with opcode 00h selects the lower area, 01h the upper area and 50h the spare area. The start column is the first address byte for the lower area, 256 plus that byte for the upper area, and 512 plus the masked byte for the spare area.
- R2: After `rst`, or after a command cycle with opcode FFh, the pointer is in the lower area and `ready` is high. An FFh command also ends any load or read in progress, so later strobes give no output.
- R3: The lower and spare selections persist: an address entry that has no new command before it uses the same area again.
- R4: The upper-area selection is one-shot. When its address entry completes, the pointer falls back to the lower area for the next address entry.
- R5: An address entry is `ADDR_CYCLES` address cycles. The first carries the column byte and the rest carry the row, low byte first. Nothing starts before the last cycle.
- R6: In the spare area only the low `SPARE_BITS` bits of the column byte count, and the higher bits are ignored.
- R7: After an entry completes, `ready` is low for exactly `LOAD_CYCLES` consecutive cycles and then returns high.
- R8: When `ready` is high with a read active, each `re_strobe` cycle with `ce_n` low sets `dout_valid` for one cycle in the next cycle. `dout` then carries cell(row, col) = ((col mod 256) + 29·row + 64·(col div 256)) mod 256, OR 1. The column then advances, up to column 511+2^SPARE_BITS.
- R9: Strobes give no output while `ready` is low, while `ce_n` is high, or when no read is active.
- R10: A strobe after the last column, with `ce_n` low and the mode off, gives no data. It loads row+1: `ready` goes low for `LOAD_CYCLES` cycles, and output resumes at column 0.
- R11: If the row is the last page of its block (row mod `PAGES_PER_BLOCK` = `PAGES_PER_BLOCK`−1), a strobe after the last column gives `dout_valid` with `dout` = 0. `ready` stays high, and every later strobe does the same.
- R12: With `ce_dc_mode` high, a strobe after the last column never loads a page. It behaves as in R11.
- R13: If `ce_n` is high for more than `CE_HOLD` consecutive sampled cycles, the read ends. A high stretch of at most `CE_HOLD` cycles leaves it running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cmd_latch | input | 1 | Marks a command cycle on `io_in` |
| addr_latch | input | 1 | Marks an address cycle on `io_in` |
| io_in | input | 8 | Command or address byte |
| re_strobe | input | 1 | One-cycle read-enable pulse |
| ce_dc_mode | input | 1 | Disables automatic next-page continuation |
| ready | output | 1 | High when no page load is in progress |
| dout | output | 8 | Output data byte |
| dout_valid | output | 1 | One-cycle qualifier for `dout` |

## Verification
The bench uses `ADDR_CYCLES`=4 (the larger-density address entry), `PAGES_PER_BLOCK`=4, `LOAD_CYCLES`=10, `CE_HOLD`=3 and `SPARE_BITS`=4. The short block lets a few strobes reach both a mid-block page continuation and a last-page boundary, because the spare area can be entered a handful of columns from the page end. The short hold makes it cheap to compare a high chip-enable stretch of exactly `CE_HOLD` cycles with one that exceeds it.

// File: rtl/nand_rdptr_pkg.sv
package nand_rdptr_pkg;

    localparam logic [7:0] OPC_AREA_LO  = 8'h00;
    localparam logic [7:0] OPC_AREA_HI  = 8'h01;
    localparam logic [7:0] OPC_AREA_SP  = 8'h50;
    localparam logic [7:0] OPC_RESET    = 8'hFF;
    localparam int unsigned COL_W       = 10;

    typedef enum logic [1:0] {
        AREA_LO = 2'd0,
        AREA_HI = 2'd1,
        AREA_SP = 2'd2
    } area_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOAD = 2'd1,
        SQ_READ = 2'd2,
        SQ_HALT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             done;
    } rd_pos_t;

    function automatic logic [COL_W-1:0] start_column(
        input area_e        a,
        input logic [7:0]   b,
        input int unsigned  spare_bits
    );
        logic [7:0] mask;
        mask = 8'((32'd1 << spare_bits) - 32'd1);
        case (a)
            AREA_LO: start_column = {2'b00, b};
            AREA_HI: start_column = {2'b01, b};
            default: start_column = {2'b10, b & mask};
        endcase
    endfunction

    function automatic logic [7:0] cell_value(
        input logic [31:0]      row,
        input logic [COL_W-1:0] col
    );
        logic [7:0] v;
        v = col[7:0] + row[7:0] * 8'd29 + {col[9:8], 6'b0};
        cell_value = v | 8'h01;
    endfunction

endpackage

// File: rtl/nand_rdptr_cmd.sv
module nand_rdptr_cmd
    import nand_rdptr_pkg::*;
#(
    parameter int unsigned ADDR_CYCLES = 4,
    parameter int unsigned SPARE_BITS  = 4,
    localparam int unsigned RB         = 8 * (ADDR_CYCLES - 1),
    localparam int unsigned IDX_W      = $clog2(ADDR_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             cmd_latch,
    input  logic             addr_latch,
    input  logic [7:0]       io_in,
    output area_e            ptr_area,
    output logic             start_v,
    output area_e            start_area,
    output logic [COL_W-1:0] start_col,
    output logic [RB-1:0]    start_row,
    output logic             rst_cmd
);
    logic [IDX_W-1:0] idx;
    logic [7:0]       col_byte;
    logic [RB-1:0]    row_acc;
    logic [RB-1:0]    row_full;

    always_comb begin
        row_full = row_acc;
        row_full[RB-1 -: 8] = io_in;
    end

    always_ff @(posedge clk) begin
        start_v <= 1'b0;
        rst_cmd <= 1'b0;
        if (rst) begin
            ptr_area   <= AREA_LO;
            start_area <= AREA_LO;
            idx        <= '0;
            col_byte   <= '0;
            row_acc    <= '0;
            start_col  <= '0;
            start_row  <= '0;
        end else if (!ce_n && cmd_latch) begin
            case (io_in)
                OPC_AREA_LO: begin ptr_area <= AREA_LO; idx <= '0; end
                OPC_AREA_HI: begin ptr_area <= AREA_HI; idx <= '0; end
                OPC_AREA_SP: begin ptr_area <= AREA_SP; idx <= '0; end
                OPC_RESET:   begin ptr_area <= AREA_LO; idx <= '0; rst_cmd <= 1'b1; end
                default: ;
            endcase
        end else if (!ce_n && addr_latch) begin
            if (idx == '0) begin
                col_byte <= io_in;
            end else begin
                row_acc[8*(int'(idx)-1) +: 8] <= io_in;
            end
            if (idx == IDX_W'(ADDR_CYCLES - 1)) begin
                idx        <= '0;
                start_v    <= 1'b1;
                start_area <= ptr_area;
                start_col  <= start_column(ptr_area, col_byte, SPARE_BITS);
                start_row  <= row_full;
                if (ptr_area == AREA_HI) begin
                    ptr_area <= AREA_LO;
                end
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_rdptr_cehold.sv
module nand_rdptr_cehold #(
    parameter int unsigned CE_HOLD = 3,
    localparam int unsigned CW     = $clog2(CE_HOLD + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    output logic term
);
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ce_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != CW'(CE_HOLD + 1)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign term = ce_n && (hi_cnt == CW'(CE_HOLD));
endmodule

// File: rtl/nand_rdptr_seq.sv
module nand_rdptr_seq
    import nand_rdptr_pkg::*;
#(
    parameter int unsigned RB              = 24,
    parameter int unsigned PAGES_PER_BLOCK = 4,
    parameter int unsigned LOAD_CYCLES     = 10,
    parameter int unsigned SPARE_BITS      = 4,
    localparam int unsigned PG_W           = $clog2(PAGES_PER_BLOCK),
    localparam int unsigned LW             = $clog2(LOAD_CYCLES + 1),
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(511 + (1 << SPARE_BITS))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start_v,
    input  logic [COL_W-1:0] start_col,
    input  logic [RB-1:0]    start_row,
    input  logic             re_ok,
    input  logic             ce_dc_mode,
    output logic             ready,
    output logic [7:0]       dout,
    output logic             dout_valid
);
    seq_state_e    state;
    rd_pos_t       pos;
    logic [RB-1:0] row;
    logic [LW-1:0] cnt;
    logic          last_page;

    assign last_page = (row[PG_W-1:0] == PG_W'(PAGES_PER_BLOCK - 1));
    assign ready     = (state != SQ_LOAD);

    always_ff @(posedge clk) begin
        dout_valid <= 1'b0;
        if (rst) begin
            state <= SQ_IDLE;
            pos   <= '0;
            row   <= '0;
            cnt   <= '0;
            dout  <= '0;
        end else if (abort) begin
            state <= SQ_IDLE;
        end else if (start_v) begin
            state    <= SQ_LOAD;
            cnt      <= LW'(LOAD_CYCLES - 1);
            pos.col  <= start_col;
            pos.done <= 1'b0;
            row      <= start_row;
        end else begin
            case (state)
                SQ_LOAD: begin
                    if (cnt == '0) state <= SQ_READ;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_READ: begin
                    if (re_ok) begin
                        if (!pos.done) begin
                            dout       <= cell_value(32'(row), pos.col);
                            dout_valid <= 1'b1;
                            if (pos.col == LAST_COL) pos.done <= 1'b1;
                            else                     pos.col  <= pos.col + 1'b1;
                        end else if (!ce_dc_mode && !last_page) begin
                            row      <= row + 1'b1;
                            pos.col  <= '0;
                            pos.done <= 1'b0;
                            cnt      <= LW'(LOAD_CYCLES - 1);
                            state    <= SQ_LOAD;
                        end else begin
                            dout       <= '0;
                            dout_valid <= 1'b1;
                            state      <= SQ_HALT;
                        end
                    end
                end
                SQ_HALT: begin
                    if (re_ok) begin
                        dout       <= '0;
                        dout_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nand_rdptr_ctrl.sv
module nand_rdptr_ctrl
    import nand_rdptr_pkg::*;
#(
    parameter int unsigned ADDR_CYCLES     = 4,
    parameter int unsigned PAGES_PER_BLOCK = 32,
    parameter int unsigned LOAD_CYCLES     = 25,
    parameter int unsigned CE_HOLD         = 4,
    parameter int unsigned SPARE_BITS      = 4,
    localparam int unsigned RB             = 8 * (ADDR_CYCLES - 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       cmd_latch,
    input  logic       addr_latch,
    input  logic [7:0] io_in,
    input  logic       re_strobe,
    input  logic       ce_dc_mode,
    output logic       ready,
    output logic [7:0] dout,
    output logic       dout_valid
);
    area_e            ptr_area;
    area_e            start_area;
    logic             start_v;
    logic [COL_W-1:0] start_col;
    logic [RB-1:0]    start_row;
    logic             rst_cmd;
    logic             ce_term;

    nand_rdptr_cmd #(
        .ADDR_CYCLES (ADDR_CYCLES),
        .SPARE_BITS  (SPARE_BITS)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .cmd_latch  (cmd_latch),
        .addr_latch (addr_latch),
        .io_in      (io_in),
        .ptr_area   (ptr_area),
        .start_v    (start_v),
        .start_area (start_area),
        .start_col  (start_col),
        .start_row  (start_row),
        .rst_cmd    (rst_cmd)
    );

    nand_rdptr_cehold #(
        .CE_HOLD (CE_HOLD)
    ) u_cehold (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .term (ce_term)
    );

    nand_rdptr_seq #(
        .RB              (RB),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .LOAD_CYCLES     (LOAD_CYCLES),
        .SPARE_BITS      (SPARE_BITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (rst_cmd | ce_term),
        .start_v    (start_v),
        .start_col  (start_col),
        .start_row  (start_row),
        .re_ok      (re_strobe & ~ce_n),
        .ce_dc_mode (ce_dc_mode),
        .ready      (ready),
        .dout       (dout),
        .dout_valid (dout_valid)
    );
endmodule

// File: rtl/nand_rdptr_ctrl_chk.sv
module nand_rdptr_ctrl_chk
    import nand_rdptr_pkg::*;
#(
    parameter int unsigned LOAD_CYCLES = 25,
    parameter int unsigned SPARE_BITS  = 4,
    localparam int unsigned LW         = $clog2(LOAD_CYCLES + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             ce_n,
    input logic             ready,
    input logic             dout_valid,
    input area_e            ptr_area,
    input area_e            start_area,
    input logic             start_v,
    input logic [COL_W-1:0] start_col
);
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || ready)                          low_cnt <= '0;
        else if (low_cnt != LW'(LOAD_CYCLES + 1)) low_cnt <= low_cnt + 1'b1;
    end

    p_ptr_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr_area == AREA_LO);

    p_hi_oneshot_r4: assert property (@(posedge clk) disable iff (rst)
        (start_v && start_area == AREA_HI) |-> ptr_area == AREA_LO);

    p_spare_range_r6: assert property (@(posedge clk) disable iff (rst)
        (start_v && start_area == AREA_SP) |->
        (start_col >= COL_W'(512) && start_col <= COL_W'(511 + (1 << SPARE_BITS))));

    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        !ready |-> low_cnt < LW'(LOAD_CYCLES));

    p_busy_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !dout_valid);

    p_ce_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> !dout_valid);
endmodule

bind nand_rdptr_ctrl nand_rdptr_ctrl_chk #(
    .LOAD_CYCLES (LOAD_CYCLES),
    .SPARE_BITS  (SPARE_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .ready      (ready),
    .dout_valid (dout_valid),
    .ptr_area   (ptr_area),
    .start_area (start_area),
    .start_v    (start_v),
    .start_col  (start_col)
);

// File: tb/nand_rdptr_ctrl_tb.sv
module nand_rdptr_ctrl_tb;
    localparam int ADDR_CYCLES = 4;
    localparam int PPB         = 4;
    localparam int LOADC       = 10;
    localparam int CEH         = 3;
    localparam int SPB         = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b0;
    logic       cmd_latch = 1'b0;
    logic       addr_latch = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic       re_strobe = 1'b0;
    logic       ce_dc_mode = 1'b0;
    logic       ready;
    logic [7:0] dout;
    logic       dout_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    nand_rdptr_ctrl #(
        .ADDR_CYCLES     (ADDR_CYCLES),
        .PAGES_PER_BLOCK (PPB),
        .LOAD_CYCLES     (LOADC),
        .CE_HOLD         (CEH),
        .SPARE_BITS      (SPB)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .cmd_latch  (cmd_latch),
        .addr_latch (addr_latch),
        .io_in      (io_in),
        .re_strobe  (re_strobe),
        .ce_dc_mode (ce_dc_mode),
        .ready      (ready),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    function automatic logic [7:0] exp_cell(input int row, input int col);
        int v;
        v = ((col % 256) + 29 * row + 64 * (col / 256)) % 256;
        return 8'(v) | 8'h01;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] op);
        @(negedge clk); cmd_latch = 1'b1; io_in = op;
        @(negedge clk); cmd_latch = 1'b0;
    endtask

    task automatic send_addr(input int col, input int row);
        for (int i = 0; i < ADDR_CYCLES; i++) begin
            @(negedge clk);
            addr_latch = 1'b1;
            io_in = (i == 0) ? 8'(col) : 8'(row >> (8 * (i - 1)));
        end
        @(negedge clk); addr_latch = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_re(output logic v, output logic [7:0] d);
        @(negedge clk); re_strobe = 1'b1;
        @(negedge clk); re_strobe = 1'b0;
        v = dout_valid; d = dout;
    endtask

    task automatic start_read(input int col, input int row, input string req);
        int n;
        send_addr(col, row);
        @(negedge clk);
        count_low(n);
        check(req, n, LOADC);
    endtask

    task automatic read_expect(input int row, input int col, input string req);
        logic v; logic [7:0] d;
        pulse_re(v, d);
        check({req, " valid"}, int'(v), 1);
        check({req, " data"}, int'(d), int'(exp_cell(row, col)));
    endtask

    task automatic t_reset;
        logic v; logic [7:0] d;
        check("R2 ready after reset", int'(ready), 1);
        check("R2 valid after reset", int'(dout_valid), 0);
        pulse_re(v, d);
        check("R9 strobe with no read", int'(v), 0);
    endtask

    task automatic t_area_lo;
        int n;
        send_cmd(8'h00);
        for (int i = 0; i < ADDR_CYCLES - 1; i++) begin
            @(negedge clk); addr_latch = 1'b1; io_in = (i == 0) ? 8'd5 : (i == 1 ? 8'd6 : 8'd0);
        end
        @(negedge clk); addr_latch = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R5 no load before last cycle", int'(ready), 1);
        end
        @(negedge clk); addr_latch = 1'b1; io_in = 8'd0;
        @(negedge clk); addr_latch = 1'b0;
        @(negedge clk);
        count_low(n);
        check("R7 load length", n, LOADC);
        for (int c = 5; c < 9; c++) read_expect(6, c, "R1 R8 lower area");
    endtask

    task automatic t_busy_ignore;
        logic v; logic [7:0] d;
        int n;
        send_cmd(8'h00);
        send_addr(20, 2);
        pulse_re(v, d);
        check("R9 strobe during load", int'(v), 0);
        count_low(n);
        read_expect(2, 20, "R9 column not advanced by busy strobe");
    endtask

    task automatic t_area_hi;
        send_cmd(8'h01);
        start_read(8'h10, 3, "R7 upper load");
        read_expect(3, 272, "R1 upper area");
        read_expect(3, 273, "R8 upper next");
        start_read(8'h10, 3, "R7 reload");
        read_expect(3, 16, "R4 upper one-shot");
    endtask

    task automatic t_area_sp;
        logic v; logic [7:0] d;
        int n;
        send_cmd(8'h50);
        start_read(8'hF3, 5, "R7 spare load");
        read_expect(5, 515, "R6 spare mask");
        start_read(8'h0D, 5, "R7 spare reload");
        read_expect(5, 525, "R3 spare persists");
        read_expect(5, 526, "R8 spare");
        read_expect(5, 527, "R8 last column");
        pulse_re(v, d);
        check("R10 no data on rollover", int'(v), 0);
        count_low(n);
        check("R10 next page load length", n, LOADC);
        read_expect(6, 0, "R10 next page col 0");
        read_expect(6, 1, "R10 next page col 1");
    endtask

    task automatic t_block_end;
        logic v; logic [7:0] d;
        send_cmd(8'h50);
        start_read(8'h0E, 7, "R7 boundary load");
        read_expect(7, 526, "R8 boundary");
        read_expect(7, 527, "R8 boundary last");
        for (int k = 0; k < 2; k++) begin
            pulse_re(v, d);
            check("R11 boundary valid", int'(v), 1);
            check("R11 boundary zero", int'(d), 0);
            check("R11 boundary ready", int'(ready), 1);
        end
    endtask

    task automatic t_dontcare;
        logic v; logic [7:0] d;
        ce_dc_mode = 1'b1;
        send_cmd(8'h50);
        start_read(8'h0F, 4, "R7 dc load");
        read_expect(4, 527, "R8 dc last");
        pulse_re(v, d);
        check("R12 dc valid", int'(v), 1);
        check("R12 dc zero", int'(d), 0);
        @(negedge clk);
        check("R12 dc no load", int'(ready), 1);
        ce_dc_mode = 1'b0;
    endtask

    task automatic t_ce_hold;
        logic v; logic [7:0] d;
        send_cmd(8'h00);
        start_read(0, 9, "R7 ce load");
        read_expect(9, 0, "R8 ce first");
        @(negedge clk); ce_n = 1'b1; re_strobe = 1'b1;
        @(negedge clk); re_strobe = 1'b0;
        check("R9 strobe with ce high", int'(dout_valid), 0);
        @(negedge clk);
        ce_n = 1'b0;
        read_expect(9, 1, "R13 short ce high keeps read");
        @(negedge clk); ce_n = 1'b1;
        repeat (CEH + 2) @(negedge clk);
        ce_n = 1'b0;
        pulse_re(v, d);
        check("R13 long ce high ends read", int'(v), 0);
    endtask

    task automatic t_reset_cmd;
        logic v; logic [7:0] d;
        send_cmd(8'h00);
        send_addr(1, 1);
        @(negedge clk);
        check("R7 load begun", int'(ready), 0);
        send_cmd(8'hFF);
        @(negedge clk);
        check("R2 FF ends load", int'(ready), 1);
        pulse_re(v, d);
        check("R2 no read after FF", int'(v), 0);
        send_cmd(8'h50);
        send_cmd(8'hFF);
        start_read(8'h10, 2, "R7 post-FF load");
        read_expect(2, 16, "R2 pointer lower after FF");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_area_lo();
        t_busy_ignore();
        t_area_hi();
        t_area_sp();
        t_block_end();
        t_dontcare();
        t_ce_hold();
        t_reset_cmd();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule